// File: doc/BRIEF.md
# SPI Loopback Self-Test Controller

This block runs a power-on self-test of an SPI master. When started, it puts the master into internal loopback mode. It then sweeps a series of packet lengths. For each length it writes a byte pattern, derived from that length, into the transmit buffer and launches one transfer through a start/done handshake with the SPI byte engine. When the engine reports completion, it reads the looped-back receive buffer and compares every byte against the same pattern.

Completion is polled at a fixed spacing, and the number of polls is bounded. The first data mismatch or expired poll budget aborts the test. Loopback mode is dropped as soon as the test ends, whether it passed or failed. A one-cycle completion pulse then reports pass, data failure or timeout. On a failure the failing length and the failing byte index are held on output ports.

Top module: `spi_lb_selftest`

## Requirements
- R1: After reset, `loop_en`, `xfer_start`, `tx_we`, `done`, `pass`, `err_data` and `err_timeout` are all low.
- R2: `loop_en` rises on the edge that accepts `start`, before any buffer write or transfer. It stays high through every write and transfer, and is low in the cycle `done` is high, on pass and on fail alike.
- R3: Packet lengths begin at MIN_LEN and grow by STEP_LEN as long as they do not exceed MAX_LEN. The whole sweep runs REPEATS times (1, 9, ..., 257 for the defaults). Each transfer is launched by a one-cycle `xfer_start` with `xfer_len` equal to the packet length.
- R4: Before each transfer, exactly L bytes are written to `tx_addr` 0 to L-1 in ascending order, one per cycle. Byte i carries (L + i) mod 256.
- R5: After completion, receive bytes 0 to L-1 are read through `rx_addr`, with `rx_rdata` valid one cycle after the address. Each byte is compared with (L + i) mod 256. `pass` is set only after the last length of the last repetition matches.
- R6: On the first mismatching byte the test stops and launches no further transfer. `err_data` is set, `fail_len` holds L and `fail_idx` holds the byte index i.
- R7: `xfer_done` is a level. It is sampled POLL_CYCLES-1 cycles after the cycle in which `xfer_start` is high, and then every POLL_CYCLES cycles. A completion seen at the last allowed poll is still accepted.
- R8: If `xfer_done` is low at all POLL_LIMIT polls, `err_timeout` is set, `fail_len` holds the current length and `fail_idx` is 0. `done` rises POLL_LIMIT*POLL_CYCLES+1 cycles after the `xfer_start` cycle.
- R9: `start` has no effect while a test is running.
- R10: `done` is a one-cycle pulse. Exactly one of `pass`, `err_data` and `err_timeout` is set when it rises. The results are held until the next accepted `start`, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a self-test (accepted when idle) |
| loop_en | output | 1 | Loopback mode request to the SPI master |
| xfer_start | output | 1 | One-cycle transfer launch to the byte engine |
| xfer_len | output | LEN_W | Byte count of the launched transfer |
| xfer_done | input | 1 | Transfer-complete level from the byte engine |
| tx_we | output | 1 | Transmit buffer write enable |
| tx_addr | output | LEN_W | Transmit buffer byte address |
| tx_wdata | output | 8 | Transmit buffer write data |
| rx_addr | output | LEN_W | Receive buffer read address |
| rx_rdata | input | 8 | Receive buffer read data, one cycle after address |
| done | output | 1 | One-cycle end-of-test pulse |
| pass | output | 1 | Test passed |
| err_data | output | 1 | Test failed on a data mismatch |
| err_timeout | output | 1 | Test failed on a transfer timeout |
| fail_len | output | LEN_W | Packet length at which the test failed |
| fail_idx | output | LEN_W | Byte index of the mismatch (0 on timeout) |

## Verification
The bench runs the full default sweep, twice over, against a loopback engine model. This covers lengths up to 257, where the pattern wraps past 255. The engine's completion latency is set so that it is caught at the first poll, at the very last poll, and one cycle after the last poll. This separates correct poll spacing from off-by-one budgets, and the late case also measures the exact timeout latency. Single corrupted bytes are injected at the first byte of the first packet, mid-packet at length 17, and at the final byte of the longest packet. These show that the abort happens at the first error, that the reported length and index are right, and that the last compare in the read pipeline is not lost. A second `start` pulse in the middle of a run shows that a running test is not restarted.

// File: rtl/lb_selftest_pkg.sv
// Shared types and helpers for the SPI loopback self-test controller.
// Assumes packet lengths fit in 16 bits.
package lb_selftest_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_WAIT,
        ST_CHECK,
        ST_DRAIN,
        ST_FINISH
    } lb_state_e;

    // Width of length/index fields: enough for MAX_LEN, never under a byte.
    function automatic int lb_len_width(input int max_len);
        int w;
        w = $clog2(max_len + 1);
        return (w > 8) ? w : 8;
    endfunction

    // Test byte for position idx of a packet of length len.
    function automatic logic [7:0] lb_pattern(input logic [15:0] len, input logic [15:0] idx);
        return 8'(len + idx);
    endfunction

endpackage

// File: rtl/lb_len_sweep.sv
// Packet-length sweep counter.
// Holds the current packet length and the repetition number. It steps
// through MIN_LEN, MIN_LEN+STEP_LEN, ... up to MAX_LEN, REPEATS times.
// Assumes first and adv are never high together.
module lb_len_sweep #(
    parameter int MIN_LEN  = 1,
    parameter int STEP_LEN = 8,
    parameter int MAX_LEN  = 260,
    parameter int REPEATS  = 1,
    parameter int LEN_W    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first,
    input  logic             adv,
    output logic [LEN_W-1:0] cur_len,
    output logic             last
);
    localparam int REP_W = $clog2(REPEATS) + 1;

    logic [REP_W-1:0] rep;
    logic [LEN_W:0]   next_sum;
    logic             wrap;

    // Next candidate length and whether it leaves the range.
    always_comb begin
        next_sum = {1'b0, cur_len} + (LEN_W+1)'(STEP_LEN);
        wrap     = next_sum > (LEN_W+1)'(MAX_LEN);
        last     = wrap && (rep == REP_W'(REPEATS - 1));
    end

    // Length and repetition registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_len <= LEN_W'(MIN_LEN);
            rep     <= '0;
        end else if (first) begin
            cur_len <= LEN_W'(MIN_LEN);
            rep     <= '0;
        end else if (adv) begin
            if (wrap) begin
                cur_len <= LEN_W'(MIN_LEN);
                rep     <= rep + 1'b1;
            end else begin
                cur_len <= next_sum[LEN_W-1:0];
            end
        end
    end

    assert_len_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_len >= LEN_W'(MIN_LEN)) && (cur_len <= LEN_W'(MAX_LEN)));

    assert_rep_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rep < REP_W'(REPEATS));

endmodule

// File: rtl/lb_poll_timer.sv
// Completion poll timer.
// After load, it raises poll once every POLL_CYCLES cycles while run is
// high, the first poll falling POLL_CYCLES-1 cycles after the first run
// cycle. last_poll marks the POLL_LIMIT-th poll.
// Assumes POLL_CYCLES >= 2, so a stale completion level is never sampled
// in the launch cycle.
module lb_poll_timer #(
    parameter int POLL_CYCLES = 200000,
    parameter int POLL_LIMIT  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic poll,
    output logic last_poll
);
    localparam int GAP_W = $clog2(POLL_CYCLES + 1);
    localparam int CNT_W = $clog2(POLL_LIMIT + 1);

    logic [GAP_W-1:0] gap;
    logic [CNT_W-1:0] polls;

    // Poll strobe and final-poll flag.
    always_comb begin
        poll      = run && (gap == '0);
        last_poll = poll && (polls == CNT_W'(POLL_LIMIT - 1));
    end

    // Spacing countdown and poll counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap   <= '0;
            polls <= '0;
        end else if (load) begin
            gap   <= GAP_W'(POLL_CYCLES - 1);
            polls <= '0;
        end else if (run) begin
            if (gap == '0) begin
                gap   <= GAP_W'(POLL_CYCLES - 1);
                polls <= polls + 1'b1;
            end else begin
                gap <= gap - 1'b1;
            end
        end
    end

    assert_poll_budget_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (polls < CNT_W'(POLL_LIMIT)));

    assert_poll_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (poll && (POLL_CYCLES > 1)) |=> !poll);

endmodule

// File: rtl/lb_pattern_cmp.sv
// Receive-data comparator.
// Tracks one outstanding buffer read (one-cycle read latency) and flags a
// byte that differs from the length-seeded pattern.
// Assumes len is stable while reads are being issued.
module lb_pattern_cmp
    import lb_selftest_pkg::*;
#(
    parameter int LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [LEN_W-1:0] issue_idx,
    input  logic [LEN_W-1:0] len,
    input  logic [7:0]       rdata,
    output logic             mismatch,
    output logic [LEN_W-1:0] cmp_idx
);
    logic             valid_q;
    logic [LEN_W-1:0] idx_q;
    logic [7:0]       expected;

    // Track which byte the returning read data belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            idx_q   <= '0;
        end else begin
            valid_q <= issue;
            idx_q   <= issue_idx;
        end
    end

    // Compare returned byte with its expected value.
    always_comb begin
        expected = lb_pattern(16'(len), 16'(idx_q));
        mismatch = valid_q && (rdata != expected);
        cmp_idx  = idx_q;
    end

    assert_cmp_idx_in_packet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (issue_idx < len));

endmodule

// File: rtl/spi_lb_selftest.sv
// SPI loopback self-test controller (top).
// On start it requests loopback mode and sweeps the packet lengths. Per
// length it fills the transmit buffer with the length-seeded pattern,
// launches one transfer, polls for completion with a bounded budget and
// checks the receive buffer. It ends with a done pulse and a result.
// Assumes the byte engine holds xfer_done as a level, clears it after
// seeing xfer_start, and that the receive buffer has a one-cycle read
// latency.
module spi_lb_selftest
    import lb_selftest_pkg::*;
#(
    parameter int MIN_LEN     = 1,
    parameter int STEP_LEN    = 8,
    parameter int MAX_LEN     = 260,
    parameter int REPEATS     = 1,
    parameter int POLL_CYCLES = 200000,
    parameter int POLL_LIMIT  = 1000,
    localparam int LEN_W      = lb_len_width(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             loop_en,
    output logic             xfer_start,
    output logic [LEN_W-1:0] xfer_len,
    input  logic             xfer_done,
    output logic             tx_we,
    output logic [LEN_W-1:0] tx_addr,
    output logic [7:0]       tx_wdata,
    output logic [LEN_W-1:0] rx_addr,
    input  logic [7:0]       rx_rdata,
    output logic             done,
    output logic             pass,
    output logic             err_data,
    output logic             err_timeout,
    output logic [LEN_W-1:0] fail_len,
    output logic [LEN_W-1:0] fail_idx
);
    lb_state_e        state;
    logic [LEN_W-1:0] idx;
    logic [LEN_W-1:0] cur_len;
    logic             sweep_last;
    logic             sweep_first;
    logic             sweep_adv;
    logic             tmr_load;
    logic             tmr_run;
    logic             poll;
    logic             last_poll;
    logic             cmp_issue;
    logic             mismatch;
    logic [LEN_W-1:0] cmp_idx;
    logic             idx_last;

    lb_len_sweep #(
        .MIN_LEN (MIN_LEN),
        .STEP_LEN(STEP_LEN),
        .MAX_LEN (MAX_LEN),
        .REPEATS (REPEATS),
        .LEN_W   (LEN_W)
    ) u_sweep (
        .clk    (clk),
        .rst_n  (rst_n),
        .first  (sweep_first),
        .adv    (sweep_adv),
        .cur_len(cur_len),
        .last   (sweep_last)
    );

    lb_poll_timer #(
        .POLL_CYCLES(POLL_CYCLES),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .run      (tmr_run),
        .poll     (poll),
        .last_poll(last_poll)
    );

    lb_pattern_cmp #(
        .LEN_W(LEN_W)
    ) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (cmp_issue),
        .issue_idx(idx),
        .len      (cur_len),
        .rdata    (rx_rdata),
        .mismatch (mismatch),
        .cmp_idx  (cmp_idx)
    );

    // Control strobes and buffer-side outputs decoded from the state.
    always_comb begin
        idx_last    = (idx == (cur_len - LEN_W'(1)));
        sweep_first = (state == ST_IDLE) && start;
        sweep_adv   = (state == ST_DRAIN) && !mismatch && !sweep_last;
        tmr_load    = (state == ST_FILL) && idx_last;
        tmr_run     = (state == ST_WAIT);
        cmp_issue   = (state == ST_CHECK);
        tx_we       = (state == ST_FILL);
        tx_addr     = idx;
        tx_wdata    = lb_pattern(16'(cur_len), 16'(idx));
        rx_addr     = idx;
        xfer_len    = cur_len;
    end

    // Test sequencer: fill, launch, poll, check, advance, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            idx         <= '0;
            loop_en     <= 1'b0;
            xfer_start  <= 1'b0;
            done        <= 1'b0;
            pass        <= 1'b0;
            err_data    <= 1'b0;
            err_timeout <= 1'b0;
            fail_len    <= '0;
            fail_idx    <= '0;
        end else begin
            xfer_start <= 1'b0;
            done       <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        loop_en     <= 1'b1;
                        pass        <= 1'b0;
                        err_data    <= 1'b0;
                        err_timeout <= 1'b0;
                        fail_len    <= '0;
                        fail_idx    <= '0;
                        idx         <= '0;
                        state       <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (idx_last) begin
                        idx        <= '0;
                        xfer_start <= 1'b1;
                        state      <= ST_WAIT;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (poll && xfer_done) begin
                        idx   <= '0;
                        state <= ST_CHECK;
                    end else if (last_poll) begin
                        err_timeout <= 1'b1;
                        fail_len    <= cur_len;
                        fail_idx    <= '0;
                        state       <= ST_FINISH;
                    end
                end
                ST_CHECK: begin
                    if (mismatch) begin
                        err_data <= 1'b1;
                        fail_len <= cur_len;
                        fail_idx <= cmp_idx;
                        state    <= ST_FINISH;
                    end else if (idx_last) begin
                        state <= ST_DRAIN;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (mismatch) begin
                        err_data <= 1'b1;
                        fail_len <= cur_len;
                        fail_idx <= cmp_idx;
                        state    <= ST_FINISH;
                    end else if (sweep_last) begin
                        pass  <= 1'b1;
                        state <= ST_FINISH;
                    end else begin
                        idx   <= '0;
                        state <= ST_FILL;
                    end
                end
                ST_FINISH: begin
                    loop_en <= 1'b0;
                    done    <= 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_loop_at_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> loop_en);

    assert_loop_at_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_we |-> loop_en);

    assert_loop_off_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !loop_en);

    assert_launch_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    assert_fill_in_packet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_we |-> (tx_addr < xfer_len));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_single_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({pass, err_data, err_timeout}) == 1));

    assert_results_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_en && !done && !start) |=> ($stable(pass) && $stable(err_data) && $stable(err_timeout)));

endmodule

// File: tb/sim_spi_lb_selftest.sv
`timescale 1ns/1ps
module sim_spi_lb_selftest;
    localparam int MINL = 1;
    localparam int STEP = 8;
    localparam int MAXL = 260;
    localparam int REP  = 2;
    localparam int PC   = 3;
    localparam int PL   = 4;
    localparam int LW   = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          loop_en, xfer_start, xfer_done, tx_we;
    logic [LW-1:0] xfer_len, tx_addr, rx_addr, fail_len, fail_idx;
    logic [7:0]    tx_wdata, rx_rdata;
    logic          done, pass, err_data, err_timeout;

    logic [7:0] tx_mem [0:MAXL-1];
    logic [7:0] rx_mem [0:MAXL-1];

    int nchk = 0, nerr = 0, cyc = 0;
    int resp_delay = 1, bad_len = -1, bad_idx = -1;
    int eng_cnt = 0, eng_len = 0;
    bit eng_act = 0;
    bit running = 0;
    int exp_len = MINL, wr_cnt = 0, nxfer = 0, t_xs = 0, t_done = 0;
    int per_sweep = 0;

    always #2.5 clk = ~clk;

    spi_lb_selftest #(
        .MIN_LEN(MINL), .STEP_LEN(STEP), .MAX_LEN(MAXL), .REPEATS(REP),
        .POLL_CYCLES(PC), .POLL_LIMIT(PL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .loop_en(loop_en),
        .xfer_start(xfer_start), .xfer_len(xfer_len), .xfer_done(xfer_done),
        .tx_we(tx_we), .tx_addr(tx_addr), .tx_wdata(tx_wdata),
        .rx_addr(rx_addr), .rx_rdata(rx_rdata), .done(done), .pass(pass),
        .err_data(err_data), .err_timeout(err_timeout),
        .fail_len(fail_len), .fail_idx(fail_idx)
    );

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // Buffers and loopback byte engine model.
    always @(posedge clk) begin
        if (tx_we) tx_mem[tx_addr] <= tx_wdata;
        rx_rdata <= rx_mem[rx_addr];
        if (!rst_n) begin
            xfer_done <= 1'b0;
            eng_act   <= 1'b0;
        end else if (xfer_start) begin
            xfer_done <= 1'b0;
            eng_act   <= 1'b1;
            eng_cnt   <= 1;
            eng_len   <= int'(xfer_len);
        end else if (eng_act) begin
            if (eng_cnt == resp_delay) begin
                xfer_done <= 1'b1;
                eng_act   <= 1'b0;
                for (int i = 0; i < MAXL; i++)
                    if (i < eng_len)
                        rx_mem[i] <= loop_en ?
                            (tx_mem[i] ^ ((eng_len == bad_len && i == bad_idx) ? 8'h40 : 8'h00)) : 8'hFF;
            end else begin
                eng_cnt <= eng_cnt + 1;
            end
        end
    end

    // Port monitor: expected sequence computed from the requirements.
    always @(negedge clk) begin
        if (rst_n) begin
            if (start && !running) begin
                running = 1; exp_len = MINL; wr_cnt = 0; nxfer = 0;
            end
            if (tx_we) begin
                check(loop_en, "R2 loop mode during fill", loop_en, 1);
                check(int'(tx_addr) == wr_cnt, "R4 fill address", tx_addr, wr_cnt);
                check(tx_wdata == 8'(exp_len + wr_cnt), "R4 fill data", tx_wdata, (exp_len + wr_cnt) % 256);
                wr_cnt++;
            end
            if (xfer_start) begin
                check(int'(xfer_len) == exp_len, "R3 transfer length", xfer_len, exp_len);
                check(wr_cnt == exp_len, "R4 bytes written before launch", wr_cnt, exp_len);
                check(loop_en, "R2 loop mode at launch", loop_en, 1);
                t_xs = cyc; nxfer++; wr_cnt = 0;
                if (exp_len + STEP <= MAXL) exp_len += STEP; else exp_len = MINL;
            end
            if (done) begin
                running = 0; t_done = cyc;
                check(!loop_en, "R2 loop mode cleared at end", loop_en, 0);
            end
        end
    end

    task automatic run_once(input int d, input int bl, input int bi, input bit mid_start);
        int n;
        resp_delay = d; bad_len = bl; bad_idx = bi;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        check(!pass && !err_data && !err_timeout, "R10 results cleared by start",
              {pass, err_data, err_timeout}, 0);
        check(loop_en, "R2 loop mode raised on start", loop_en, 1);
        if (mid_start) begin
            repeat (400) @(posedge clk);
            #1 start = 1'b1;   // R9: pulse while running
            @(posedge clk); #1 start = 1'b0;
        end
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done && n < 60000);
        check(n < 60000, "watchdog run did not end", n, 0);
        @(negedge clk);
        check(!done, "R10 done is a single pulse", done, 0);
    endtask

    initial begin
        for (int i = 0; i < MAXL; i++) rx_mem[i] = 8'h00;
        for (int l = MINL; l <= MAXL; l += STEP) per_sweep++;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!loop_en && !xfer_start && !tx_we, "R1 reset outputs low",
              {loop_en, xfer_start, tx_we}, 0);
        check(!done && !pass && !err_data && !err_timeout, "R1 reset results low",
              {done, pass, err_data, err_timeout}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!loop_en && !tx_we && !done, "R1 idle after reset", {loop_en, tx_we, done}, 0);

        // Fast engine, full sweep twice, with a restart attempt mid-run.
        run_once(1, -1, -1, 1'b1);
        check(pass && !err_data && !err_timeout, "R5 pass after clean sweep",
              {pass, err_data, err_timeout}, 4);
        check(nxfer == REP * per_sweep, "R3 R9 transfer count", nxfer, REP * per_sweep);
        check(!loop_en, "R2 loop mode off after pass", loop_en, 0);

        // Completion seen only at the last allowed poll.
        run_once(PL * PC - 2, -1, -1, 1'b0);
        check(pass && !err_timeout, "R7 completion at last poll accepted", {pass, err_timeout}, 2);
        check(nxfer == REP * per_sweep, "R7 transfer count", nxfer, REP * per_sweep);

        // Completion one cycle too late: timeout on first packet.
        run_once(PL * PC - 1, -1, -1, 1'b0);
        check(err_timeout && !err_data && !pass, "R8 timeout reported",
              {pass, err_data, err_timeout}, 1);
        check(int'(fail_len) == MINL, "R8 timeout length", fail_len, MINL);
        check(fail_idx == '0, "R8 timeout index", fail_idx, 0);
        check(t_done - t_xs == PL * PC + 1, "R8 timeout latency", t_done - t_xs, PL * PC + 1);
        check(nxfer == 1, "R8 no transfer after timeout", nxfer, 1);

        // Mid-packet mismatch.
        run_once(1, 17, 5, 1'b0);
        check(err_data && !pass && !err_timeout, "R6 mismatch reported",
              {pass, err_data, err_timeout}, 2);
        check(int'(fail_len) == 17, "R6 failing length", fail_len, 17);
        check(int'(fail_idx) == 5, "R6 failing index", fail_idx, 5);
        check(nxfer == 3, "R6 abort stops sweep", nxfer, 3);
        check(!loop_en, "R2 loop mode off after fail", loop_en, 0);

        // Last byte of the longest packet (pattern wrapped).
        run_once(1, 257, 256, 1'b0);
        check(err_data && int'(fail_len) == 257, "R6 R5 last packet length", fail_len, 257);
        check(int'(fail_idx) == 256, "R5 last byte index drained", fail_idx, 256);
        check(nxfer == per_sweep, "R6 transfers until last packet", nxfer, per_sweep);

        // First byte of the first packet.
        run_once(2, 1, 0, 1'b0);
        check(err_data && int'(fail_len) == 1 && fail_idx == '0, "R6 first byte mismatch",
              fail_idx, 0);
        check(nxfer == 1, "R6 single transfer", nxfer, 1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule